// File: doc/BRIEF.md
# Aligned Quadword Load-Store Unit

This unit carries out 128-bit load and store instructions over a memory port that moves 64 bits per transfer. It accepts a 32-bit instruction word together with the value of the base register and, for stores, the 128-bit store value. It forms the effective address and clears its low four bits, so the access always lands on a 16-byte boundary. It then performs two ordered 64-bit transfers: the lower half goes first, then the upper half eight bytes above it.

Each transfer uses a valid/ready handshake toward memory, and the second transfer is presented only after the first has been accepted. When both transfers are finished the unit raises a one-cycle completion pulse. For a load, that same cycle carries the 128-bit result, its destination register index and a write enable. A load whose destination is register 0 makes no memory access and writes nothing. A store from register 0 still writes both halves. Misaligned addresses never raise a fault; they are aligned without notice.

Top module: `qword_lsu`

## Requirements
- R1: Bits 31:26 of `instr` select the operation: 6'b011110 is a load and 6'b011111 is a store. Bits 20:16 give the data register index and bits 15:0 give the offset. An instruction with any other value in bits 31:26 is dropped: no memory request is made and no `done` pulse follows.
- R2: The address is `base_val` plus the offset sign-extended to ADDR_W bits, with bits 3:0 of the sum cleared.
- R3: The first transfer uses the aligned address and carries the low 64 bits. The second uses the aligned address plus 8 and carries the high 64 bits. The second is presented only after the first has completed.
- R4: A load with register index 0 makes no memory transfer. `done` pulses one cycle after acceptance, with `load_we` low.
- R5: A store with register index 0 still makes both transfers and writes the `store_data` supplied.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_wdata` and `mem_write` hold steady. The transfer waits until `mem_ready` is sampled high.
- R7: `done` is high for exactly one cycle, in the cycle after the second transfer completes. For a load, `load_data`, `load_rd` and `load_we`=1 are valid in that cycle. With `mem_ready` held high, `done` comes 3 cycles after acceptance.
- R8: Data is little-endian within each 64-bit half. `store_data[7:0]` is the byte at the aligned address (`mem_wdata[7:0]` of the first transfer). `load_data[63:0]` is the first transfer's read data and `load_data[127:64]` is the second's.
- R9: `req_ready` is high only while the unit is idle. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle and able to accept |
| instr | input | 32 | Instruction word |
| base_val | input | ADDR_W | Base register value |
| store_data | input | 128 | Value to store |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts or completes the transfer |
| mem_write | output | 1 | 1 for a write transfer |
| mem_addr | output | ADDR_W | Transfer byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| load_we | output | 1 | Load result to be written |
| load_rd | output | 5 | Destination register index |
| load_data | output | 128 | Load result |

## Verification
The request is accepted on the clock edge where `req_valid` is sampled high. The first transfer is presented in the next cycle, and with no wait states `done` follows 3 cycles after acceptance. A load to register 0 completes after 1 cycle. Each memory wait cycle adds one cycle to its transfer. The bench drives inputs on falling edges, counts falling edges from acceptance until `done`, compares that count with the figure from these rules, and samples all results on that same falling edge. A memory model in the bench logs the address of every completed transfer. The logged addresses and their count confirm alignment, ordering and the case where no access is made.

// File: rtl/qword_lsu.sv
module qword_lsu #(
  parameter int ADDR_W = 32,
  parameter logic [5:0] OP_LOAD  = 6'b011110,
  parameter logic [5:0] OP_STORE = 6'b011111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [127:0]      store_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic              load_we,
  output logic [4:0]        load_rd,
  output logic [127:0]      load_data
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic [127:0]      wdata_q;
  logic              store_q;
  logic              wr_q;
  logic [4:0]        rt_q;

  logic [5:0]        op;
  logic [4:0]        rt;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] eff;
  logic              is_ld, is_st, take;

  assign op      = instr[31:26];
  assign rt      = instr[20:16];
  assign off_ext = {{(ADDR_W-16){instr[15]}}, instr[15:0]};
  assign eff     = base_val + off_ext;
  assign is_ld   = (op == OP_LOAD);
  assign is_st   = (op == OP_STORE);
  assign take    = req_valid && req_ready;

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state == S_LO) || (state == S_HI);
  assign mem_write = store_q;
  assign mem_addr  = {addr_q[ADDR_W-1:4], (state == S_HI), 3'b000};
  assign mem_wdata = (state == S_HI) ? wdata_q[127:64] : wdata_q[63:0];
  assign done      = (state == S_DONE);
  assign load_we   = done && wr_q;
  assign load_rd   = rt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      store_q   <= 1'b0;
      wr_q      <= 1'b0;
      rt_q      <= '0;
      load_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (take && (is_ld || is_st)) begin
          addr_q  <= {eff[ADDR_W-1:4], 4'b0000};
          wdata_q <= store_data;
          store_q <= is_st;
          rt_q    <= rt;
          wr_q    <= is_ld && (rt != 5'd0);
          if (is_ld && rt == 5'd0) state <= S_DONE;
          else                     state <= S_LO;
        end
        S_LO: if (mem_ready) begin
          if (!store_q) load_data[63:0] <= mem_rdata;
          state <= S_HI;
        end
        S_HI: if (mem_ready) begin
          if (!store_q) load_data[127:64] <= mem_rdata;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_addr[3]) |=> (mem_valid && mem_addr[3]));

  a_r7_done_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_addr[3]) |=> done);

  a_r2_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] == 3'b000));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> (load_rd != 5'd0 && done));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !req_ready);
endmodule

// File: tb/qword_lsu_tb_top.sv
module qword_lsu_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   instr = '0;
  logic [AW-1:0] base_val = '0;
  logic [127:0]  store_data = '0;
  logic          mem_valid, mem_ready, mem_write;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;
  logic          done, load_we;
  logic [4:0]    load_rd;
  logic [127:0]  load_data;

  int checks = 0;
  int fails = 0;
  int stall_cfg = 0;
  int wait_cnt = 0;
  int beat_cnt = 0;
  logic [AW-1:0] log_addr [16];
  logic [63:0] mem [32];

  always #2 clk = ~clk;

  qword_lsu #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .instr(instr), .base_val(base_val), .store_data(store_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .load_we(load_we), .load_rd(load_rd), .load_data(load_data)
  );

  function automatic logic [63:0] pat(int i);
    return {32'hC0DE0000 | 32'(i), 32'h0BAD0000 | (32'(i) << 8)};
  endfunction

  assign mem_ready = (wait_cnt >= stall_cfg);
  assign mem_rdata = mem[mem_addr[7:3]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= pat(i);
      wait_cnt <= 0;
    end else if (mem_valid) begin
      if (mem_ready) begin
        wait_cnt <= 0;
        log_addr[beat_cnt % 16] <= mem_addr;
        beat_cnt <= beat_cnt + 1;
        if (mem_write) mem[mem_addr[7:3]] <= mem_wdata;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rt, logic [15:0] off);
    return {op, 5'd3, rt, off};
  endfunction

  int lat;
  bit seen;

  task automatic issue(input logic [31:0] ins, input logic [AW-1:0] b, input logic [127:0] sd);
    @(negedge clk);
    req_valid = 1'b1; instr = ins; base_val = b; store_data = sd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; seen = 0;
    while (lat < 40 && !done) begin
      @(negedge clk);
      lat++;
    end
    seen = done;
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R9 idle ready after reset", 128'(req_ready), 128'd1);
    check(mem_valid == 1'b0, "R9 no request after reset", 128'(mem_valid), 128'd0);
    check(done == 1'b0, "R7 no done after reset", 128'(done), 128'd0);
  endtask

  task automatic t_load_basic;
    int b0 = beat_cnt;
    issue(mk(6'b011110, 5'd5, 16'h0000), 32'h40, '0);
    check(seen && lat == 3, "R7 load latency", 128'(lat), 128'd3);
    check(load_we && load_rd == 5'd5, "R7 load write enable/rd", {load_we, load_rd}, {1'b1, 5'd5});
    check(load_data == {pat(9), pat(8)}, "R8 load halves", load_data, {pat(9), pat(8)});
    check(beat_cnt - b0 == 2 && log_addr[b0 % 16] == 32'h40 && log_addr[(b0 + 1) % 16] == 32'h48,
          "R3 beat order", {log_addr[b0 % 16], log_addr[(b0 + 1) % 16]}, {32'h40, 32'h48});
    @(negedge clk);
    check(!done && req_ready, "R7 done single cycle", {done, req_ready}, 2'b01);
  endtask

  task automatic t_load_misaligned;
    int b0 = beat_cnt;
    issue(mk(6'b011110, 5'd9, 16'hFFF5), 32'h5F, '0);
    check(log_addr[b0 % 16] == 32'h50 && log_addr[(b0 + 1) % 16] == 32'h58,
          "R2 negative offset aligned", {log_addr[b0 % 16], log_addr[(b0 + 1) % 16]}, {32'h50, 32'h58});
    check(load_data == {pat(11), pat(10)}, "R2 misaligned load data", load_data, {pat(11), pat(10)});
  endtask

  task automatic t_store;
    logic [127:0] sd = 128'h0F0E0D0C0B0A0908_0706050403020100;
    int b0 = beat_cnt;
    issue(mk(6'b011111, 5'd7, 16'h0003), 32'h60, sd);
    check(seen && lat == 3 && !load_we, "R7 store done without write", {lat, load_we}, {32'd3, 1'b0});
    check(mem[12] == sd[63:0] && mem[13] == sd[127:64], "R3 store halves", {mem[13], mem[12]}, sd);
    check(mem[12][7:0] == 8'h00 && mem[12][15:8] == 8'h01, "R8 little-endian bytes", 128'(mem[12][15:0]), 128'h0100);
    check(beat_cnt - b0 == 2, "R3 two store beats", 128'(beat_cnt - b0), 128'd2);
  endtask

  task automatic t_store_r0;
    logic [127:0] sd = 128'hDEADBEEF_00000001_CAFEF00D_00000002;
    int b0 = beat_cnt;
    issue(mk(6'b011111, 5'd0, 16'h0000), 32'h70, sd);
    check(beat_cnt - b0 == 2, "R5 store r0 beats", 128'(beat_cnt - b0), 128'd2);
    check(mem[14] == sd[63:0] && mem[15] == sd[127:64], "R5 store r0 data", {mem[15], mem[14]}, sd);
  endtask

  task automatic t_load_r0;
    int b0 = beat_cnt;
    issue(mk(6'b011110, 5'd0, 16'h0010), 32'h40, '0);
    check(seen && lat == 1, "R4 r0 load latency", 128'(lat), 128'd1);
    check(!load_we, "R4 r0 load no write", 128'(load_we), 128'd0);
    check(beat_cnt == b0, "R4 r0 load no beats", 128'(beat_cnt - b0), 128'd0);
  endtask

  task automatic t_other_op;
    int b0 = beat_cnt;
    int dn = 0;
    @(negedge clk);
    req_valid = 1'b1; instr = mk(6'b011100, 5'd4, 16'h0); base_val = 32'h40;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (done || mem_valid) dn++;
      @(negedge clk);
    end
    check(dn == 0 && beat_cnt == b0, "R1 other opcode dropped", 128'(dn), 128'd0);
    check(req_ready, "R1 still idle", 128'(req_ready), 128'd1);
  endtask

  task automatic t_stall;
    stall_cfg = 2;
    @(negedge clk);
    req_valid = 1'b1; instr = mk(6'b011110, 5'd31, 16'h0008); base_val = 32'h20;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && mem_valid, "R9 busy not ready", {req_ready, mem_valid}, 2'b01);
    lat = 1;
    while (lat < 40 && !done) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 7, "R6 stalled latency", 128'(lat), 128'd7);
    check(load_data == {pat(5), pat(4)} && load_rd == 5'd31, "R6 stalled load data", load_data, {pat(5), pat(4)});
    stall_cfg = 0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_basic();
    t_load_misaligned();
    t_store();
    t_store_r0();
    t_load_r0();
    t_other_op();
    t_stall();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule